// File: doc/BRIEF.md
# Key-Size-Selectable Iterative Block Encryption Engine

This block encrypts one 128-bit block with the AES cipher. It performs one complete round per clock cycle. The key length is chosen per block by a two-bit code: 128, 192 or 256 bits, which gives 10, 12 or 14 rounds. The state is kept in a single 128-bit register and is read as a 4x4 matrix of bytes, column-major. Byte 0 sits in bits [127:120], and byte `r+4c` is row `r`, column `c`.

Key expansion is not part of the block. The engine drives an index, `round_idx`, and the surrounding logic must put round key number `round_idx` on `round_key` combinationally in the same cycle. A start pulse adds round key 0 to the plaintext. Then come the full rounds: substitution, row rotation, column mixing and key addition. The last round drops the column mixing. `done` pulses when the ciphertext is ready, and the ciphertext then holds until the next accepted start.

Top module: `aes_keysel_core`

## Requirements
- R1: After reset, `done` is 0, `round_idx` is 0 and `ciphertext` is all zeros.
- R2: With `key_sel` = 2'b00 (128-bit key), the engine returns the standard AES-128 ciphertext. `done` rises 10 cycles after the start edge.
- R3: With `key_sel` = 2'b01 (192-bit key), the engine returns the standard AES-192 ciphertext after 12 rounds.
- R4: With `key_sel` = 2'b10 (256-bit key), the engine returns the standard AES-256 ciphertext after 14 rounds.
- R5: `key_sel` = 2'b11 behaves exactly as 2'b00: 10 rounds and the AES-128 result.
- R6: `round_idx` is 0 while idle, so round key 0 is applied at the start edge. It then steps 1, 2, … up to Nr on consecutive cycles and returns to 0 when `done` rises.
- R7: A `start` asserted while a block is in progress is ignored. The result, the latency and the index sequence all stay unchanged.
- R8: `done` is high for exactly one cycle. `ciphertext` keeps its value while idle until a new start is accepted.
- R9: `key_sel` and `plaintext` are sampled only on the accepted start edge. Later changes have no effect on the running block.
- R10: A start asserted in the same cycle that `done` is high is accepted, and `round_idx` reads 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a block (accepted only when idle) |
| key_sel | input | 2 | Key-length code: 00=128, 01=192, 10=256, 11=128 |
| plaintext | input | 128 | Input block, byte 0 in bits [127:120] |
| round_key | input | 128 | Round key selected by `round_idx`, same cycle |
| round_idx | output | 4 | Index of the round key needed this cycle |
| done | output | 1 | One-cycle pulse: ciphertext valid |
| ciphertext | output | 128 | Result block, held until the next start |

## Verification
Two events can fall in the same cycle: the end of one block and the start request for the next. A collision also arises when a start request lands in the middle of a busy run. The bench provokes the first case by raising `start` in the cycle where `done` is seen high. The second run must then begin at once, with `round_idx` reading 1 and the correct ciphertext after the correct number of cycles. The busy case is provoked by pulsing `start` mid-run with a different plaintext and key code. It is judged by an unchanged index sequence, latency and result.

// File: rtl/aes_keysel_pkg.sv
// Shared constants and finite-field helpers for the key-size-selectable engine.
// Assumes the byte-column layout: byte 0 in the top bits, column-major state.
package aes_keysel_pkg;

    localparam int BLK_W     = 128;
    localparam int BYTE_W    = 8;
    localparam int N_BYTES   = BLK_W / BYTE_W;
    localparam int N_COLS    = 4;
    localparam int IDX_W     = 4;
    localparam int NR_SHORT  = 10;
    localparam int NR_MID    = 12;
    localparam int NR_LONG   = 14;
    localparam logic [7:0] RED_POLY = 8'h1B;

    // Multiply by {02} in GF(2^8)
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? RED_POLY : 8'h00);
    endfunction

    // Multiply by {03} in GF(2^8)
    function automatic logic [7:0] gf_x3(input logic [7:0] a);
        return gf_x2(a) ^ a;
    endfunction

    // General GF(2^8) product, shift-and-add
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // Round count for a key-length code; the unused code maps to the short key
    function automatic logic [IDX_W-1:0] rounds_for(input logic [1:0] code);
        case (code)
            2'b01:   return IDX_W'(NR_MID);
            2'b10:   return IDX_W'(NR_LONG);
            default: return IDX_W'(NR_SHORT);
        endcase
    endfunction

endpackage

// File: rtl/aes_sbox_calc.sv
// Byte substitution computed from first principles: inverse in GF(2^8)
// (as a^254, with 0 mapping to 0) followed by the fixed affine map.
// Purely combinational; no stored table.
module aes_sbox_calc
    import aes_keysel_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] inv;

    // Raise to the 254th power by chaining squares and products
    always_comb begin
        logic [7:0] sq;
        logic [7:0] prod;
        sq   = gf_mul(din, din);
        prod = sq;
        for (int k = 2; k < 8; k++) begin
            sq   = gf_mul(sq, sq);
            prod = gf_mul(prod, sq);
        end
        inv = prod;
    end

    // Affine map: xor of four left rotations plus constant 0x63
    always_comb begin
        dout = inv
             ^ {inv[6:0], inv[7]}
             ^ {inv[5:0], inv[7:6]}
             ^ {inv[4:0], inv[7:5]}
             ^ {inv[3:0], inv[7:4]}
             ^ 8'h63;
    end

endmodule

// File: rtl/aes_round_xform.sv
// One cipher round on a 128-bit state: byte substitution, row rotation,
// optional column mixing (skipped when final is high) and key addition.
// Assumes column-major byte order with byte 0 in bits [127:120].
module aes_round_xform
    import aes_keysel_pkg::*;
(
    input  logic [BLK_W-1:0] state_in,
    input  logic [BLK_W-1:0] rkey,
    input  logic             final_rnd,
    output logic [BLK_W-1:0] state_out
);
    logic [BYTE_W-1:0] sub_b   [N_BYTES];
    logic [BYTE_W-1:0] shift_b [N_BYTES];
    logic [BYTE_W-1:0] mix_b   [N_BYTES];
    logic [BLK_W-1:0]  pre_key;

    genvar g;
    generate
        for (g = 0; g < N_BYTES; g++) begin : g_byte
            localparam int ROW = g % 4;
            localparam int COL = g / 4;
            localparam int SRC = ROW + 4 * ((COL + ROW) % N_COLS);

            // Substitute each byte independently
            aes_sbox_calc u_sbox (
                .din  (state_in[(N_BYTES-1-g)*BYTE_W +: BYTE_W]),
                .dout (sub_b[g])
            );

            // Row r takes its byte from column c+r (mod 4)
            assign shift_b[g] = sub_b[SRC];
        end

        for (g = 0; g < N_COLS; g++) begin : g_col
            // Column mixing: circulant {02,03,01,01}
            always_comb begin
                logic [7:0] a0, a1, a2, a3;
                a0 = shift_b[4*g];
                a1 = shift_b[4*g+1];
                a2 = shift_b[4*g+2];
                a3 = shift_b[4*g+3];
                mix_b[4*g]   = gf_x2(a0) ^ gf_x3(a1) ^ a2 ^ a3;
                mix_b[4*g+1] = a0 ^ gf_x2(a1) ^ gf_x3(a2) ^ a3;
                mix_b[4*g+2] = a0 ^ a1 ^ gf_x2(a2) ^ gf_x3(a3);
                mix_b[4*g+3] = gf_x3(a0) ^ a1 ^ a2 ^ gf_x2(a3);
            end
        end

        for (g = 0; g < N_BYTES; g++) begin : g_pack
            // Choose mixed or unmixed byte before key addition
            assign pre_key[(N_BYTES-1-g)*BYTE_W +: BYTE_W] = final_rnd ? shift_b[g] : mix_b[g];
        end
    endgenerate

    // Key addition on the whole block
    assign state_out = pre_key ^ rkey;

endmodule

// File: rtl/aes_round_seq.sv
// Round sequencer: accepts start only when idle, latches the round count
// from the key-length code, steps the round index each cycle and pulses
// done after the final round.
module aes_round_seq
    import aes_keysel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       key_sel,
    output logic             load,
    output logic             busy,
    output logic             last,
    output logic [IDX_W-1:0] round,
    output logic [IDX_W-1:0] nr_q,
    output logic             done
);
    assign load = start && !busy;
    assign last = busy && (round == nr_q);

    // Control state: busy flag, round counter, latched round count, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            round <= '0;
            nr_q  <= IDX_W'(NR_SHORT);
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy  <= 1'b1;
                round <= IDX_W'(1);
                nr_q  <= rounds_for(key_sel);
            end else if (last) begin
                busy  <= 1'b0;
                round <= '0;
                done  <= 1'b1;
            end else if (busy) begin
                round <= round + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/aes_keysel_core.sv
// Top level: iterative block encryption, one round per cycle, key length
// selected per block. Round keys are supplied externally by index on the
// same cycle. The state register doubles as the held ciphertext.
module aes_keysel_core
    import aes_keysel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       key_sel,
    input  logic [127:0]     plaintext,
    input  logic [127:0]     round_key,
    output logic [3:0]       round_idx,
    output logic             done,
    output logic [127:0]     ciphertext
);
    logic             load;
    logic             busy;
    logic             last;
    logic [IDX_W-1:0] nr_q;
    logic [BLK_W-1:0] state_q;
    logic [BLK_W-1:0] round_out;

    aes_round_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .key_sel (key_sel),
        .load    (load),
        .busy    (busy),
        .last    (last),
        .round   (round_idx),
        .nr_q    (nr_q),
        .done    (done)
    );

    aes_round_xform u_xform (
        .state_in  (state_q),
        .rkey      (round_key),
        .final_rnd (last),
        .state_out (round_out)
    );

    // State register: whitening on start, one round per busy cycle, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= plaintext ^ round_key;
        end else if (busy) begin
            state_q <= round_out;
        end
    end

    assign ciphertext = state_q;

endmodule

// File: rtl/aes_keysel_core_chk.sv
// Temporal checks on the engine's ports and sequencer state.
module aes_keysel_core_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [3:0]   round_idx,
    input logic [127:0] ciphertext,
    input logic         busy,
    input logic [3:0]   nr_q
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(ciphertext));

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && round_idx != nr_q) |=> (round_idx == $past(round_idx) + 4'd1));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_idx <= 4'd14);

    // R2
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && round_idx == nr_q) |=> (done && round_idx == 4'd0));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (round_idx != 4'd1));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (round_idx == 4'd1));

endmodule

bind aes_keysel_core aes_keysel_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .round_idx  (round_idx),
    .ciphertext (ciphertext),
    .busy       (busy),
    .nr_q       (nr_q)
);

// File: tb/aes_keysel_core_test.sv
// Directed bench: computes round keys with its own key schedule and checks
// published ciphertexts, latency, index sequence and hold behaviour.
module aes_keysel_core_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   key_sel = 2'b00;
    logic [127:0] plaintext = '0;
    logic [127:0] round_key;
    logic [3:0]   round_idx;
    logic         done;
    logic [127:0] ciphertext;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]   sb [256];
    logic [127:0] rk_tab [15];

    always #5 clk = ~clk;

    assign round_key = rk_tab[round_idx];

    aes_keysel_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .key_sel    (key_sel),
        .plaintext  (plaintext),
        .round_key  (round_key),
        .round_idx  (round_idx),
        .done       (done),
        .ciphertext (ciphertext)
    );

    localparam logic [127:0] PT_C  = 128'h00112233445566778899aabbccddeeff;
    localparam logic [255:0] KEY_C = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    localparam logic [127:0] CT128 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] CT192 = 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
    localparam logic [127:0] CT256 = 128'h8ea2b7ca516745bfeafc49904b496089;
    localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [255:0] KEY_B = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;

    task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mul2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= s;
            s = mul2(s);
        end
        return r;
    endfunction

    // Substitution table by exhaustive inverse search plus affine map
    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] o;
            for (int y = 1; y < 256; y++)
                if (x != 0 && fmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
            sb[x] = o ^ 8'h63;
        end
    endtask

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    // Standard key schedule into the round-key table
    task automatic expand(input int nk, input logic [255:0] key);
        logic [31:0] w [60];
        logic [7:0]  rc = 8'h01;
        int nr = nk + 6;
        for (int i = 0; i < nk; i++) w[i] = key[255 - 32*i -: 32];
        for (int i = nk; i < 4*(nr+1); i++) begin
            logic [31:0] t = w[i-1];
            if (i % nk == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = mul2(rc);
            end else if (nk > 6 && i % nk == 4) begin
                t = subw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int r = 0; r < 15; r++)
            rk_tab[r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : 128'h0;
    endtask

    // One block; disturb: 1 = mid-run start pulse, 2 = mid-run key_sel/plaintext change
    task automatic run_block(input string req, input logic [1:0] code, input int nk,
                             input logic [127:0] pt, input logic [255:0] key,
                             input logic [127:0] exp, input int disturb);
        int nr = nk + 6;
        int cyc = 0;
        expand(nk, key);
        start = 1'b1; key_sel = code; plaintext = pt;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        while (!done && cyc < 40) begin
            check(req, "round_idx step (R6)", 128'(round_idx), 128'(cyc + 1));
            if (cyc == 3 && disturb == 1) begin
                start = 1'b1; key_sel = 2'b10; plaintext = ~pt;
            end
            if (cyc == 3 && disturb == 2) begin
                key_sel = ~code; plaintext = ~pt;
            end
            @(posedge clk); #1;
            start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        check(req, "latency", 128'(cyc), 128'(nr));
        check(req, "ciphertext", ciphertext, exp);
        check(req, "round_idx back to 0 (R6)", 128'(round_idx), 128'h0);
    endtask

    // Done is one pulse and result holds while idle inputs wiggle
    task automatic hold_test(input logic [127:0] exp);
        @(posedge clk); @(negedge clk);
        check("R8", "done single pulse", 128'(done), 128'h0);
        for (int i = 0; i < 5; i++) begin
            plaintext = {4{32'(i) ^ 32'hdeadbeef}};
            key_sel = 2'(i);
            @(posedge clk); @(negedge clk);
            check("R8", "ciphertext held", ciphertext, exp);
            check("R8", "done stays low", 128'(done), 128'h0);
        end
    endtask

    initial begin
        for (int r = 0; r < 15; r++) rk_tab[r] = '0;
        build_sbox();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "done at reset", 128'(done), 128'h0);
        check("R1", "round_idx at reset", 128'(round_idx), 128'h0);
        check("R1", "ciphertext at reset", ciphertext, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run_block("R2", 2'b00, 4, PT_C, KEY_C, CT128, 0);
        hold_test(CT128);
        run_block("R2", 2'b00, 4, PT_B, KEY_B, CT_B, 0);
        // R10: next start issued in the done cycle
        run_block("R3", 2'b01, 6, PT_C, KEY_C, CT192, 0);
        run_block("R10", 2'b10, 8, PT_C, KEY_C, CT256, 0);
        @(negedge clk);
        run_block("R4", 2'b10, 8, PT_C, KEY_C, CT256, 0);
        @(negedge clk);
        run_block("R5", 2'b11, 4, PT_C, KEY_C, CT128, 0);
        @(negedge clk);
        run_block("R7", 2'b00, 4, PT_C, KEY_C, CT128, 1);
        @(negedge clk);
        run_block("R9", 2'b01, 6, PT_C, KEY_C, CT192, 2);
        hold_test(CT192);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule